// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two operands over several clock cycles, using one adder of operand width and one double-width partial-product register. A single-cycle start pulse, given while the block is idle, captures both operands and a mode bit that selects unsigned or two's-complement signed interpretation. The block then does one conditional add per multiplier bit. The right shift of the partial product is wired into the register load, so each multiplier bit costs exactly one clock.

The multiplier operand is loaded into the lower half of the partial-product register. It is consumed from its least significant bit while product bits move in from above. The carry out of each add goes into the top bit, so no bit is lost. In signed mode the operands are first reduced to magnitudes. One extra cycle after the last add negates the full product when the operand signs differ. The finished product is presented as an upper word and a lower word. A one-cycle done pulse marks the moment the product is ready, and the product then holds until the next accepted start.

Top module: `shiftadd_mul`

## Requirements
- R1: While reset is high and in the cycle after it is released, busy and done are 0 and both result words are 0.
- R2: With the mode bit at 0, the operands are unsigned, and {hi, lo} equals the full 2W-bit unsigned product.
- R3: With the mode bit at 1, the operands are two's-complement, and {hi, lo} equals the 2W-bit two's-complement product. This includes the most negative operand. When the product fits in W signed bits, every bit of hi equals bit W-1 of lo.
- R4: A start seen high on a rising edge while busy is 0 is accepted, and busy is 1 after that edge. Done is 1 after the (W+1)th following rising edge, and busy is 0 from that same edge on.
- R5: Done is high for exactly one cycle per accepted start, and never together with busy.
- R6: A start raised while busy is 1 is ignored. The running product and its completion time are unaffected.
- R7: Operand and mode inputs are sampled only on the accepting edge. Changing them while busy has no effect on the result.
- R8: While idle and without a start, hi and lo hold their last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request to begin a multiplication |
| op_a | input | W | Multiplicand |
| op_b | input | W | Multiplier |
| signed_mode | input | 1 | 1: two's-complement operands, 0: unsigned |
| busy | output | 1 | Multiplication in progress |
| done | output | 1 | One-cycle pulse: product ready |
| hi | output | W | Upper word of the product |
| lo | output | W | Lower word of the product |

## Verification
The bench builds the block with its default operand width of 32. This makes the full-width corner operands reachable: all ones, the most negative value, and zero. The exact completion latency of 33 edges after acceptance can then be counted against the requirement. At this width the signed case of the most negative value squared checks that the magnitude path keeps its top bit. Mixed-sign operands whose products fit in one word check the sign-extension property of the upper word.

// File: rtl/shiftadd_mul_pkg.sv
package shiftadd_mul_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_SIGN = 2'd2
    } mul_phase_e;

    typedef struct packed {
        logic load;
        logic step;
        logic fix;
    } mul_ctl_s;

endpackage

// File: rtl/shiftadd_mul_prep.sv
module shiftadd_mul_prep #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic         is_signed,
    output logic [W-1:0] a_mag,
    output logic [W-1:0] b_mag,
    output logic         negate
);
    logic a_neg;
    logic b_neg;

    always_comb begin
        a_neg  = is_signed & a_in[W-1];
        b_neg  = is_signed & b_in[W-1];
        a_mag  = a_neg ? (~a_in + W'(1)) : a_in;
        b_mag  = b_neg ? (~b_in + W'(1)) : b_in;
        negate = a_neg ^ b_neg;
    end
endmodule

// File: rtl/shiftadd_mul_step.sv
module shiftadd_mul_step #(
    parameter int W = 32
) (
    input  logic [2*W-1:0] acc_in,
    input  logic [W-1:0]   mcand,
    output logic [2*W-1:0] acc_out
);
    logic [W:0] addend;
    logic [W:0] upper_sum;

    always_comb begin
        addend    = acc_in[0] ? {1'b0, mcand} : '0;
        upper_sum = {1'b0, acc_in[2*W-1:W]} + addend;
        acc_out   = {upper_sum, acc_in[W-1:1]};
    end
endmodule

// File: rtl/shiftadd_mul_ctrl.sv
module shiftadd_mul_ctrl
    import shiftadd_mul_pkg::*;
#(
    parameter int W = 32
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    output mul_ctl_s ctl,
    output logic     busy,
    output logic     done
);
    localparam int CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    mul_phase_e phase_q;
    logic [CW-1:0] iter_q;

    always_comb begin
        ctl.load = (phase_q == PH_IDLE) && start;
        ctl.step = (phase_q == PH_RUN);
        ctl.fix  = (phase_q == PH_SIGN);
        busy     = (phase_q != PH_IDLE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            iter_q  <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            case (phase_q)
                PH_IDLE: begin
                    if (start) begin
                        phase_q <= PH_RUN;
                        iter_q  <= '0;
                    end
                end
                PH_RUN: begin
                    iter_q <= iter_q + CW'(1);
                    if (iter_q == LAST) phase_q <= PH_SIGN;
                end
                PH_SIGN: begin
                    phase_q <= PH_IDLE;
                    done    <= 1'b1;
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    // R5
    done_excl_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R5
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R4
    accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    // R6
    start_busy_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (start && busy) |=> (busy || done));

    // R4
    run_begins_zero_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (iter_q == '0));
endmodule

// File: rtl/shiftadd_mul.sv
module shiftadd_mul
    import shiftadd_mul_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic         signed_mode,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] hi,
    output logic [W-1:0] lo
);
    localparam int PW = 2 * W;

    mul_ctl_s ctl;
    logic [W-1:0]  a_mag;
    logic [W-1:0]  b_mag;
    logic          negate;
    logic [W-1:0]  mcand_q;
    logic          neg_q;
    logic [PW-1:0] acc_q;
    logic [PW-1:0] acc_next;

    shiftadd_mul_prep #(.W(W)) u_prep (
        .a_in      (op_a),
        .b_in      (op_b),
        .is_signed (signed_mode),
        .a_mag     (a_mag),
        .b_mag     (b_mag),
        .negate    (negate)
    );

    shiftadd_mul_step #(.W(W)) u_step (
        .acc_in  (acc_q),
        .mcand   (mcand_q),
        .acc_out (acc_next)
    );

    shiftadd_mul_ctrl #(.W(W)) u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .ctl   (ctl),
        .busy  (busy),
        .done  (done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q   <= '0;
            mcand_q <= '0;
            neg_q   <= 1'b0;
        end else if (ctl.load) begin
            acc_q   <= {{W{1'b0}}, b_mag};
            mcand_q <= a_mag;
            neg_q   <= negate;
        end else if (ctl.step) begin
            acc_q <= acc_next;
        end else if (ctl.fix && neg_q) begin
            acc_q <= ~acc_q + PW'(1);
        end
    end

    assign hi = acc_q[PW-1:W];
    assign lo = acc_q[W-1:0];

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable({hi, lo}));

    // R2
    unsigned_nonneg_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !neg_q) |-> (acc_q == $past(acc_q)));
endmodule

// File: tb/shiftadd_mul_bench.sv
module shiftadd_mul_bench;
    localparam int W = 32;
    localparam int NV = 10;
    localparam int LAT = W + 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic signed_mode = 1'b0;
    logic busy, done;
    logic [W-1:0] hi, lo;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    localparam logic [W-1:0] TA [NV] = '{32'd0, 32'd7, 32'hFFFF_FFFF, 32'h1234_5678,
        32'd6, 32'hFFFF_FFFA, 32'h8000_0000, 32'h8000_0000, 32'hFFFF_FFFF, 32'h7FFF_FFFF};
    localparam logic [W-1:0] TB [NV] = '{32'h9ABC_DEF0, 32'd9, 32'hFFFF_FFFF, 32'h9ABC_DEF0,
        32'hFFFF_FFF9, 32'd7, 32'h8000_0000, 32'd1, 32'hFFFF_FFFF, 32'h8000_0000};
    localparam logic TS [NV] = '{1'b0, 1'b0, 1'b0, 1'b0,
        1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1};

    shiftadd_mul #(.W(W)) u_shiftadd_mul (
        .clk(clk), .rst(rst), .start(start), .op_a(op_a), .op_b(op_b),
        .signed_mode(signed_mode), .busy(busy), .done(done), .hi(hi), .lo(lo)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic logic [2*W-1:0] expect_prod(input logic [W-1:0] a,
                                                   input logic [W-1:0] b, input logic s);
        logic [2*W-1:0] xa, xb;
        xa = s ? {{W{a[W-1]}}, a} : {{W{1'b0}}, a};
        xb = s ? {{W{b[W-1]}}, b} : {{W{1'b0}}, b};
        return xa * xb;
    endfunction

    task automatic check(input logic ok, input string req,
                         input logic [2*W-1:0] act, input logic [2*W-1:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drives start at a negedge, counts negedges until done, returns latency
    task automatic run_mul(input logic [W-1:0] a, input logic [W-1:0] b, input logic s,
                           input logic poke, output int lat);
        int n = 0;
        op_a = a; op_b = b; signed_mode = s; start = 1'b1;
        @(negedge clk);
        n = 1;
        start = 1'b0;
        check(busy == 1'b1, "R4 busy after accept", {63'd0, busy}, 64'd1);
        while (!done && n < 100) begin
            if (poke && n == 5) begin
                op_a = ~a; op_b = b + 32'd3; signed_mode = ~s; start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            n++;
        end
        start = 1'b0;
        lat = n;
    endtask

    initial begin
        int lat;
        logic [2*W-1:0] held;
        repeat (3) @(negedge clk);
        // R1
        check(!busy && !done && hi == '0 && lo == '0, "R1 reset state",
              {hi, lo}, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !done && hi == '0 && lo == '0, "R1 after release",
              {hi, lo}, 64'd0);

        for (int i = 0; i < NV; i++) begin
            run_mul(TA[i], TB[i], TS[i], 1'b0, lat);
            check({hi, lo} == expect_prod(TA[i], TB[i], TS[i]),
                  TS[i] ? "R3 signed product" : "R2 unsigned product",
                  {hi, lo}, expect_prod(TA[i], TB[i], TS[i]));
            check(lat == LAT, "R4 latency", 64'(lat), 64'(LAT));
            check(!busy, "R4 busy low at done", {63'd0, busy}, 64'd0);
            @(negedge clk);
            check(!done, "R5 done single cycle", {63'd0, done}, 64'd0);
        end

        // R3: small signed product fits one word, hi is sign extension of lo
        run_mul(32'hFFFF_FFFD, 32'd5, 1'b1, 1'b0, lat);
        check(hi == {W{lo[W-1]}} && lo == 32'hFFFF_FFF1, "R3 sign extension",
              {hi, lo}, 64'hFFFF_FFFF_FFFF_FFF1);

        // R6, R7: start and new operands during busy are ignored
        run_mul(32'hDEAD_BEEF, 32'h0000_1234, 1'b0, 1'b1, lat);
        check({hi, lo} == expect_prod(32'hDEAD_BEEF, 32'h0000_1234, 1'b0),
              "R6 R7 mid-run start ignored", {hi, lo},
              expect_prod(32'hDEAD_BEEF, 32'h0000_1234, 1'b0));
        check(lat == LAT, "R6 latency unchanged", 64'(lat), 64'(LAT));
        @(negedge clk);
        check(!done && !busy, "R6 no second run", {62'd0, busy, done}, 64'd0);

        // R8: idle with changing inputs, no start
        held = {hi, lo};
        op_a = 32'h5555_5555; op_b = 32'h3333_3333; signed_mode = 1'b1;
        repeat (6) @(negedge clk);
        check({hi, lo} == held && !busy, "R8 hold while idle", {hi, lo}, held);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule